// File: doc/BRIEF.md
# I2C Register Target

This block is a slave on a two-wire I2C bus that lets a bus master read and write a bank of 128 byte-wide registers. SCL and SDA are sampled by a fast system clock (at least ten times the bus bit rate), passed through a synchronizer and turned into START, STOP and clock-edge events. The block answers to a 7-bit device address whose six upper bits are fixed by a parameter and whose lowest bit comes from a strap input. Two targets on one bus can thus be told apart by tying their straps differently.

A transfer begins with the address byte and a write flag, followed by a sub-address byte. The low seven bits of the sub-address load the register pointer, and its top bit enables pointer increment after each data byte. Data bytes that follow are written into the register bank. To read, the master issues a repeated START and the address byte with the read flag set. The block then shifts register contents out, most significant bit first, for as long as the master acknowledges. SDA is open-drain: the block only ever pulls the line low, and it changes its drive only while SCL is low.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block does not pull SDA low and does not assert the register write strobe until a transfer addresses it.
- R2: The block acknowledges an address byte, by pulling SDA low through the ninth clock, only when bits 7:1 of that byte equal {101110, strap}. Bit 0 of that byte is the direction, with 1 meaning the master reads.
- R3: After an address that does not match, the block acknowledges nothing, writes no register and keeps SDA released until the next START.
- R4: The byte after a matched write address is the sub-address. It is acknowledged, its bits 6:0 load the register pointer, and its bit 7 set to 1 enables auto-increment.
- R5: Each data byte the master writes is acknowledged and written into the register at the pointer with exactly one single-cycle write strobe, which is issued during that byte's acknowledge phase.
- R6: With auto-increment enabled, the pointer advances by one after each data byte and wraps from 127 to 0. With it disabled, every data byte uses the same register.
- R7: After a repeated START and a matched address with the read flag, the block shifts out the register at the pointer, most significant bit first. Each master acknowledge fetches the next byte, at pointer+1 when auto-increment is on and at the same register when it is off.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R9: A START or STOP at any point, including in the middle of a byte, discards the partial byte. A START restarts address reception.
- R10: The SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaDriveLow | output | 1 | When 1, the pad pulls SDA low; when 0, the line is released |
| addrStrap | input | 1 | Sets the lowest bit of the device address |
| regAddr | output | 7 | Register pointer presented to the register bank |
| regWdata | output | 8 | Byte to be written into the register bank |
| regWe | output | 1 | Single-cycle write strobe for the register bank |
| regRdata | input | 8 | Contents of the register at regAddr |

## Verification
On every cycle, assertions check the following: a START puts the byte engine back to address reception with a cleared bit count, and a STOP returns it to idle. The SDA drive changes only while the synchronized SCL is low. Entry into the address-acknowledge state happens only after a matching address. The write strobe never lasts longer than one cycle, and the pointer either increments with wrap or holds, depending on the increment flag. The directed scenarios are the only place that shows whole-transfer behaviour: that bytes land in the right registers, including across the 127-to-0 wrap, that a mismatched or strap-flipped address is ignored, that read data arrives MSB first, that the block falls silent after a NACK, and that a byte cut off by START or STOP leaves no trace.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_MACK, ST_IGNORE
  } tgtStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadSub;
    logic ldTx;
    logic shiftTx;
    logic incPtr;
    logic wrStrobe;
  } dpCtrlT;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-1:0], sdaIn};
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclPrev  = sclPipe[STAGES];
  assign sdaPrev  = sdaPipe[STAGES];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b101110
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclLvl,
  input  logic                sdaLvl,
  input  logic                sclRise,
  input  logic                sclFall,
  input  logic                startDet,
  input  logic                stopDet,
  input  logic                addrStrap,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic                txMsb,
  output dpCtrlT              ctrl,
  output logic                sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgtStateT state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic masterNack, nackNxt;
  logic addrHit;

  assign addrHit = (rxByte[BYTE_W-1:1] == {ADDR_HI, addrStrap});

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    nackNxt  = masterNack;
    ctrl     = '0;
    if (startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt != FULL) begin
            ctrl.shiftIn = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            cntNxt = '0;
            if (state == ST_ADDR) begin
              stateNxt = addrHit ? ST_ADDR_ACK : ST_IGNORE;
            end else if (state == ST_SUB) begin
              stateNxt = ST_SUB_ACK;
              ctrl.loadSub = 1'b1;
            end else begin
              stateNxt = ST_WDATA_ACK;
              ctrl.wrStrobe = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (rxByte[0]) begin
            stateNxt = ST_RDATA;
            ctrl.ldTx = 1'b1;
          end else begin
            stateNxt = ST_SUB;
          end
        end
        ST_SUB_ACK: if (sclFall) stateNxt = ST_WDATA;
        ST_WDATA_ACK: if (sclFall) begin
          stateNxt = ST_WDATA;
          ctrl.incPtr = 1'b1;
        end
        ST_RDATA: begin
          if (sclRise && bitCnt != FULL) begin
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              stateNxt = ST_MACK;
              cntNxt = '0;
            end else begin
              ctrl.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nackNxt = sdaLvl;
            ctrl.incPtr = ~sdaLvl;
          end else if (sclFall) begin
            if (masterNack) begin
              stateNxt = ST_IGNORE;
            end else begin
              stateNxt = ST_RDATA;
              ctrl.ldTx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      masterNack <= 1'b0;
    end else begin
      state      <= stateNxt;
      bitCnt     <= cntNxt;
      masterNack <= nackNxt;
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                       (state == ST_WDATA_ACK) || ((state == ST_RDATA) && !txMsb);

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR) && (bitCnt == '0));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE));

  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLvl);

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK) |->
      ($past(rxByte[BYTE_W-1:1]) == {ADDR_HI, $past(addrStrap)}));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sdaDriveLow);
endmodule

// File: rtl/i2c_target_dp.sv
module i2c_target_dp
  import i2c_reg_pkg::*;
#(
  parameter int PTR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctrl,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] regRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe
);
  logic [BYTE_W-1:0] txReg;
  logic [PTR_W-1:0]  ptr;
  logic              autoInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txReg   <= '1;
      ptr     <= '0;
      autoInc <= 1'b0;
      regWe   <= 1'b0;
    end else begin
      regWe <= ctrl.wrStrobe;
      if (ctrl.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaLvl};
      if (ctrl.ldTx) txReg <= regRdata;
      else if (ctrl.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (ctrl.loadSub) begin
        ptr     <= rxByte[PTR_W-1:0];
        autoInc <= rxByte[BYTE_W-1];
      end else if (ctrl.incPtr && autoInc) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign txMsb    = txReg[BYTE_W-1];
  assign regAddr  = ptr;
  assign regWdata = rxByte;

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.incPtr && autoInc && !ctrl.loadSub) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.incPtr && !autoInc && !ctrl.loadSub) |=> $stable(ptr));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b101110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       addrStrap,
  output logic [6:0] regAddr,
  output logic [7:0] regWdata,
  output logic       regWe,
  input  logic [7:0] regRdata
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb;
  dpCtrlT ctrl;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_target_ctrl #(.ADDR_HI(ADDR_HI)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .addrStrap(addrStrap), .rxByte(rxByte), .txMsb(txMsb),
    .ctrl(ctrl), .sdaDriveLow(sdaDriveLow)
  );

  i2c_target_dp #(.PTR_W(BYTE_W - 1)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sdaLvl(sdaLvl), .regRdata(regRdata),
    .rxByte(rxByte), .txMsb(txMsb), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe)
  );
endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic masterSda = 1'b1;
  logic strap = 1'b0;
  logic sdaLine;
  logic sdaDriveLow, regWe;
  logic [6:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] mem [128];
  int checks = 0, errors = 0, weCount = 0, driveSeen = 0;
  logic watchDrive = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine  = masterSda & ~sdaDriveLow;
  assign regRdata = mem[regAddr];

  i2c_reg_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .addrStrap(strap), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (regWe) begin
      mem[regAddr] <= regWdata;
      weCount <= weCount + 1;
    end
    if (watchDrive && sdaDriveLow) driveSeen <= driveSeen + 1;
  end

  function automatic logic [7:0] initVal(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    masterSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    masterSda = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    masterSda = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    masterSda = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic drv, output logic smp);
    masterSda = drv; waitQ();
    scl = 1'b1; waitQ();
    smp = sdaLine; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    logic unused;
    for (int i = 7; i > 7 - n; i--) clockBit(b[i], unused);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    sendBits(b, 8);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(1'b1, b[i]);
    clockBit(nack, s);
  endtask

  task automatic writeRegs(input logic [7:0] dev, input logic [7:0] sub,
                           input logic [7:0] d [], input string req);
    logic ack;
    busStart();
    sendByte(dev, ack);   chk(ack, "R2", int'(ack), 1);
    sendByte(sub, ack);   chk(ack, "R4", int'(ack), 1);
    foreach (d[i]) begin
      sendByte(d[i], ack); chk(ack, req, int'(ack), 1);
    end
    busStop();
  endtask

  task automatic testReset();
    chk(!sdaDriveLow, "R1 drive", int'(sdaDriveLow), 0);
    chk(!regWe && weCount == 0, "R1 strobe", weCount, 0);
  endtask

  task automatic testSingleWrite();
    int w0 = weCount;
    writeRegs(8'hB8, 8'h05, '{8'hC3}, "R5");
    chk(mem[5] == 8'hC3, "R5 data", int'(mem[5]), 'hC3);
    chk(mem[6] == initVal(6), "R5 neighbour", int'(mem[6]), int'(initVal(6)));
    chk(weCount - w0 == 1, "R5 one strobe", weCount - w0, 1);
  endtask

  task automatic testWrongAddr();
    logic ack;
    int w0 = weCount;
    driveSeen = 0; watchDrive = 1'b1;
    busStart();
    sendByte(8'hBA, ack); chk(!ack, "R2 mismatch", int'(ack), 0);
    sendByte(8'h05, ack); chk(!ack, "R3 sub", int'(ack), 0);
    sendByte(8'h11, ack); chk(!ack, "R3 data", int'(ack), 0);
    busStop();
    watchDrive = 1'b0;
    chk(driveSeen == 0, "R3 quiet", driveSeen, 0);
    chk(weCount == w0 && mem[5] == 8'hC3, "R3 no write", weCount - w0, 0);
  endtask

  task automatic testStrap();
    logic ack;
    strap = 1'b1;
    writeRegs(8'hBA, 8'h20, '{8'h77}, "R5");
    chk(mem[8'h20] == 8'h77, "R2 strap high", int'(mem[8'h20]), 'h77);
    busStart();
    sendByte(8'hB8, ack); chk(!ack, "R2 strap low addr", int'(ack), 0);
    busStop();
    strap = 1'b0;
  endtask

  task automatic testWrap();
    writeRegs(8'hB8, 8'hFE, '{8'h11, 8'h22, 8'h33}, "R6");
    chk(mem[126] == 8'h11, "R6 first", int'(mem[126]), 'h11);
    chk(mem[127] == 8'h22, "R6 second", int'(mem[127]), 'h22);
    chk(mem[0] == 8'h33, "R6 wrap", int'(mem[0]), 'h33);
  endtask

  task automatic testNoInc();
    int w0 = weCount;
    writeRegs(8'hB8, 8'h10, '{8'h44, 8'h55}, "R6");
    chk(mem[16] == 8'h55, "R6 same reg", int'(mem[16]), 'h55);
    chk(mem[17] == initVal(17), "R6 no advance", int'(mem[17]), int'(initVal(17)));
    chk(weCount - w0 == 2, "R5 strobes", weCount - w0, 2);
  endtask

  task automatic readSetup(input logic [7:0] sub);
    logic ack;
    busStart();
    sendByte(8'hB8, ack); chk(ack, "R2", int'(ack), 1);
    sendByte(sub, ack);   chk(ack, "R4", int'(ack), 1);
    busStart();
    sendByte(8'hB9, ack); chk(ack, "R7 read addr", int'(ack), 1);
  endtask

  task automatic testReadInc();
    logic [7:0] b;
    readSetup(8'hFE);
    recvByte(1'b0, b); chk(b == 8'h11, "R7 byte0", int'(b), 'h11);
    recvByte(1'b0, b); chk(b == 8'h22, "R7 byte1", int'(b), 'h22);
    recvByte(1'b1, b); chk(b == 8'h33, "R7 wrap byte", int'(b), 'h33);
    driveSeen = 0; watchDrive = 1'b1;
    recvByte(1'b1, b);
    watchDrive = 1'b0;
    chk(driveSeen == 0 && b == 8'hFF, "R8 released", driveSeen, 0);
    busStop();
  endtask

  task automatic testReadNoInc();
    logic [7:0] b;
    readSetup(8'h20);
    recvByte(1'b0, b); chk(b == 8'h77, "R7 hold0", int'(b), 'h77);
    recvByte(1'b1, b); chk(b == 8'h77, "R7 hold1", int'(b), 'h77);
    busStop();
  endtask

  task automatic testAbort();
    logic ack;
    busStart();
    sendBits(8'hB8, 4);
    busStop();
    writeRegs(8'hB8, 8'h30, '{8'h9E}, "R9");
    chk(mem[48] == 8'h9E, "R9 after stop", int'(mem[48]), 'h9E);
    busStart();
    sendByte(8'hB8, ack); chk(ack, "R9 addr", int'(ack), 1);
    sendBits(8'h31, 3);
    busStart();
    sendByte(8'hB8, ack); chk(ack, "R9 restart addr", int'(ack), 1);
    sendByte(8'h32, ack); chk(ack, "R9 sub", int'(ack), 1);
    sendByte(8'h4D, ack); chk(ack, "R9 data", int'(ack), 1);
    busStop();
    chk(mem[50] == 8'h4D, "R9 target", int'(mem[50]), 'h4D);
    chk(mem[49] == initVal(49), "R9 partial dropped", int'(mem[49]), int'(initVal(49)));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = initVal(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testSingleWrite();
    testWrongAddr();
    testStrap();
    testWrap();
    testNoInc();
    testReadInc();
    testReadNoInc();
    testAbort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule